// File: doc/BRIEF.md
# Dual-Pixel Histogram Array with Double-Rate Input

This block builds a histogram of pixel values from a single pixel bus that carries one new sample on every clock edge, rising and falling. A front end samples the bus on both edges and so forms two streams at the clock rate. It delays the falling-edge stream by one rising-edge register, so that the rest of the array works on the rising edge only. The two streams then enter a linear pipeline of cells as a pair of pixels per clock.

Each cell owns two adjacent bins, 2j and 2j+1. It compares the upper PIX_W-1 bits of both pixels with its own index. It then uses the two low bits to form an increment of 0, 1 or 2 for each of its bins. Each bin keeps its count in a two-slow accumulator: two interleaved partial sums, merged by an adder into a registered bin count. The pixel pair moves one cell to the right per clock. A synchronous start pulse clears every count. A registered select port reads one bin at a time.

Top module: `hist_ddr_array`

## Requirements
- R1: After reset every bin reads zero on the readout port.
- R2: A one-cycle `start` pulse clears all bin counts and any pixel still in flight. Two rising edges after the pulse, the readout shows zero.
- R3: A valid pixel with value v < NBINS adds one to bin v. A valid pixel with value v >= NBINS changes no bin.
- R4: Samples taken on the rising edge and samples taken on the falling edge are both counted.
- R5: When both pixels of a pair hit the same bin, that bin gains two.
- R6: A sample whose valid bit is low at its capture edge changes no bin.
- R7: A continuous stream of one sample per clock edge is counted in full, with no sample lost, so N samples are taken in N/2 clock cycles.
- R8: `rd_cnt` shows the count of bin `rd_sel` one rising edge after `rd_sel` is applied. It keeps its previous value until that edge.
- R9: A sample captured on a falling edge appears in the count of the highest bin after NBINS/2+3 rising edges. It appears on `rd_cnt` one rising edge later, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the pixel bus is sampled on both edges |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Synchronous pulse that clears all counts |
| pix_ddr | input | PIX_W | Pixel value, a new one on each clock edge |
| vld_ddr | input | 1 | Valid flag for the sample on `pix_ddr`, sampled on the same edge |
| rd_sel | input | $clog2(NBINS) | Bin to read |
| rd_cnt | output | CNT_W | Registered count of the selected bin |

## Verification
The bench sends a dense stream in which a sample lands on every edge. If the design dropped the falling-edge capture, or paired it with the wrong register, about half the counts would be missing. Pairs with both pixels in one bin catch a decoder that yields 1 where it should yield 2. Values above the bin range catch a cell that compares too few bits and folds them into low bins. Low-valid samples catch counts that ignore the valid bit. A single falling-edge sample routed to the last cell pins the latency to the exact edge, which exposes a missing or extra pipeline stage. A start pulse after a full histogram catches a clear that misses one of the two interleaved partial sums.

// File: rtl/hist_pkg.sv
`timescale 1ns/1ps
package hist_pkg;

  typedef logic [1:0] inc_t;

  // Increment for one bin of a cell: each pixel that hits the cell and whose
  // low bit matches the bin parity contributes one.
  function automatic inc_t lane_inc(input logic hit_a, input logic lsb_a,
                                    input logic hit_b, input logic lsb_b,
                                    input logic parity);
    inc_t ia;
    inc_t ib;
    ia = {1'b0, hit_a && (lsb_a == parity)};
    ib = {1'b0, hit_b && (lsb_b == parity)};
    return ia + ib;
  endfunction

endpackage

// File: rtl/hist_ddr_front.sv
`timescale 1ns/1ps
module hist_ddr_front #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             vld_in,
  output logic [PIX_W-1:0] a_pix,
  output logic             a_vld,
  output logic [PIX_W-1:0] b_pix,
  output logic             b_vld
);

  logic [PIX_W-1:0] fall_pix_q;
  logic             fall_vld_q;
  logic [PIX_W-1:0] rise_pix_q, rise_pix_d;
  logic             rise_vld_q, rise_vld_d;
  logic [PIX_W-1:0] late_pix_q, late_pix_d;
  logic             late_vld_q, late_vld_d;

  // falling-edge capture of the second stream
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_pix_q <= '0;
      fall_vld_q <= 1'b0;
    end else begin
      fall_pix_q <= pix_in;
      fall_vld_q <= vld_in;
    end
  end

  always_comb begin
    rise_pix_d = pix_in;
    rise_vld_d = vld_in && !clr;
    late_pix_d = fall_pix_q;
    late_vld_d = fall_vld_q && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_pix_q <= '0;
      rise_vld_q <= 1'b0;
      late_pix_q <= '0;
      late_vld_q <= 1'b0;
    end else begin
      rise_pix_q <= rise_pix_d;
      rise_vld_q <= rise_vld_d;
      late_pix_q <= late_pix_d;
      late_vld_q <= late_vld_d;
    end
  end

  assign a_pix = rise_pix_q;
  assign a_vld = rise_vld_q;
  assign b_pix = late_pix_q;
  assign b_vld = late_vld_q;

  // R2
  front_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!a_vld && !b_vld));

endmodule

// File: rtl/hist_acc2.sv
`timescale 1ns/1ps
module hist_acc2 #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  hist_pkg::inc_t   inc,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] lane_a_q, lane_a_d;
  logic [CNT_W-1:0] lane_b_q, lane_b_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // two interleaved partial sums; the feedback loop spans two registers
  always_comb begin
    lane_a_d = lane_b_q + {{(CNT_W-2){1'b0}}, inc};
    lane_b_d = lane_a_q;
    cnt_d    = lane_a_q + lane_b_q;
    if (clr) begin
      lane_a_d = '0;
      lane_b_d = '0;
      cnt_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_a_q <= '0;
      lane_b_q <= '0;
      cnt_q    <= '0;
    end else begin
      lane_a_q <= lane_a_d;
      lane_b_q <= lane_b_d;
      cnt_q    <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R7
  sum_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (CNT_W'(lane_a_q + lane_b_q) ==
              CNT_W'($past(lane_a_q + lane_b_q) + $past({{(CNT_W-2){1'b0}}, inc}))));

  // R2
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && lane_a_q == '0 && lane_b_q == '0));

endmodule

// File: rtl/hist_cell.sv
`timescale 1ns/1ps
module hist_cell #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 19,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PIX_W-1:0] a_pix,
  input  logic             a_vld,
  input  logic [PIX_W-1:0] b_pix,
  input  logic             b_vld,
  output logic [CNT_W-1:0] even_cnt,
  output logic [CNT_W-1:0] odd_cnt
);

  localparam int HI_W = PIX_W - 1;
  localparam logic [HI_W-1:0] MY_KEY = HI_W'(IDX);

  logic a_hit, b_hit;
  hist_pkg::inc_t inc_d [2];
  hist_pkg::inc_t inc_q [2];
  logic [CNT_W-1:0] cnt_w [2];

  always_comb begin
    a_hit = a_vld && (a_pix[PIX_W-1:1] == MY_KEY);
    b_hit = b_vld && (b_pix[PIX_W-1:1] == MY_KEY);
  end

  for (genvar g = 0; g < 2; g++) begin : g_bin
    always_comb begin
      inc_d[g] = hist_pkg::lane_inc(a_hit, a_pix[0], b_hit, b_pix[0], g[0]);
      if (clr) inc_d[g] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inc_q[g] <= '0;
      else        inc_q[g] <= inc_d[g];
    end

    hist_acc2 #(.CNT_W(CNT_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (inc_q[g]),
      .cnt   (cnt_w[g])
    );
  end

  assign even_cnt = cnt_w[0];
  assign odd_cnt  = cnt_w[1];

  // R5
  inc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, inc_q[0]} + {1'b0, inc_q[1]}) <= 3'd2);

  // R6
  idle_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_vld && !b_vld) |=> (inc_q[0] == '0 && inc_q[1] == '0));

endmodule

// File: rtl/hist_ddr_array.sv
`timescale 1ns/1ps
module hist_ddr_array #(
  parameter int PIX_W = 8,
  parameter int NBINS = 8,
  parameter int CNT_W = 19
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [PIX_W-1:0]         pix_ddr,
  input  logic                     vld_ddr,
  input  logic [$clog2(NBINS)-1:0] rd_sel,
  output logic [CNT_W-1:0]         rd_cnt
);

  localparam int NCELL = NBINS / 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [PIX_W-1:0] fe_a_pix, fe_b_pix;
  logic             fe_a_vld, fe_b_vld;
  logic [NBINS*CNT_W-1:0] bins_flat;
  logic [CNT_W-1:0] rd_q, rd_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  hist_ddr_front #(.PIX_W(PIX_W)) u_front (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (start),
    .pix_in (pix_ddr),
    .vld_in (vld_ddr),
    .a_pix  (fe_a_pix),
    .a_vld  (fe_a_vld),
    .b_pix  (fe_b_pix),
    .b_vld  (fe_b_vld)
  );

  for (genvar j = 0; j < NCELL; j++) begin : g_col
    logic [PIX_W-1:0] a_pix, b_pix;
    logic             a_vld, b_vld;

    if (j == 0) begin : g_head
      assign a_pix = fe_a_pix;
      assign a_vld = fe_a_vld;
      assign b_pix = fe_b_pix;
      assign b_vld = fe_b_vld;
    end else begin : g_link
      logic [PIX_W-1:0] a_pix_q, b_pix_q;
      logic             a_vld_q, b_vld_q, a_vld_d, b_vld_d;

      always_comb begin
        a_vld_d = g_col[j-1].a_vld && !start;
        b_vld_d = g_col[j-1].b_vld && !start;
      end

      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) begin
          a_pix_q <= '0;
          b_pix_q <= '0;
          a_vld_q <= 1'b0;
          b_vld_q <= 1'b0;
        end else begin
          a_pix_q <= g_col[j-1].a_pix;
          b_pix_q <= g_col[j-1].b_pix;
          a_vld_q <= a_vld_d;
          b_vld_q <= b_vld_d;
        end
      end

      assign a_pix = a_pix_q;
      assign a_vld = a_vld_q;
      assign b_pix = b_pix_q;
      assign b_vld = b_vld_q;
    end

    hist_cell #(.PIX_W(PIX_W), .CNT_W(CNT_W), .IDX(j)) u_cell (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .clr      (start),
      .a_pix    (a_pix),
      .a_vld    (a_vld),
      .b_pix    (b_pix),
      .b_vld    (b_vld),
      .even_cnt (bins_flat[(2*j)*CNT_W +: CNT_W]),
      .odd_cnt  (bins_flat[(2*j+1)*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    rd_d = '0;
    if (int'(rd_sel) < NBINS) rd_d = bins_flat[int'(rd_sel)*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rd_q <= '0;
    else            rd_q <= rd_d;
  end

  assign rd_cnt = rd_q;

  // R2
  start_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    start |=> ##1 (rd_cnt == '0));

  // R1
  reset_read_chk: assert property (@(posedge clk)
    !rst_int_n |=> (rd_cnt == '0));

endmodule

// File: tb/hist_ddr_array_test.sv
`timescale 1ns/1ps
module hist_ddr_array_test;

  localparam int PW = 8;
  localparam int NB = 8;
  localparam int CW = 19;
  localparam int NSTIM = 18;
  localparam logic [PW-1:0] STIM [NSTIM] = '{
    8'd1, 8'd3, 8'd0, 8'd7, 8'd2, 8'd2, 8'd5, 8'd1, 8'd6,
    8'd3, 8'd4, 8'd7, 8'd0, 8'd1, 8'd5, 8'd6, 8'd3, 8'd2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PW-1:0] pix_ddr = '0;
  logic vld_ddr = 1'b0;
  logic [$clog2(NB)-1:0] rd_sel = '0;
  logic [CW-1:0] rd_cnt;

  int exp_h [NB];
  int n_chk = 0;
  int n_err = 0;
  bit next_rise = 1'b1;
  bit done = 1'b0;

  hist_ddr_array #(.PIX_W(PW), .NBINS(NB), .CNT_W(CW)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .pix_ddr (pix_ddr),
    .vld_ddr (vld_ddr),
    .rd_sel  (rd_sel),
    .rd_cnt  (rd_cnt)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int got, input int want);
    n_chk++;
    if (got != want) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, want);
    end
  endtask

  // drive one sample for the next edge slot (rising and falling alternate)
  task automatic put(input logic v, input logic [PW-1:0] d);
    if (next_rise) begin
      @(negedge clk); #1;
    end else begin
      @(posedge clk); #1;
    end
    pix_ddr = d;
    vld_ddr = v;
    if (v && int'(d) < NB) exp_h[d]++;
    next_rise = !next_rise;
  endtask

  task automatic flush();
    put(1'b0, '0);
    put(1'b0, '0);
    put(1'b0, '0);
    repeat (NB/2 + 6) @(posedge clk);
    #1;
  endtask

  task automatic read_all(input string tag);
    for (int b = 0; b < NB; b++) begin
      rd_sel = b[$clog2(NB)-1:0];
      @(posedge clk); #2;
      chk($sformatf("%s bin%0d", tag, b), int'(rd_cnt), exp_h[b]);
    end
  endtask

  task automatic do_start();
    @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int b = 0; b < NB; b++) exp_h[b] = 0;
    next_rise = 1'b1;
  endtask

  initial begin
    for (int b = 0; b < NB; b++) exp_h[b] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;

    // R1: reset state
    read_all("R1 reset");

    // R4 R7 R3: dense stream from the table, one sample per edge
    do_start();
    for (int i = 0; i < NSTIM; i++) put(1'b1, STIM[i]);
    flush();
    read_all("R4_R7 table");

    // R8: readout holds until the edge after the select changes
    rd_sel = 3'd2;
    @(posedge clk); #2;
    chk("R8 sel2", int'(rd_cnt), exp_h[2]);
    rd_sel = 3'd5;
    #1;
    chk("R8 hold before edge", int'(rd_cnt), exp_h[2]);
    @(posedge clk); #2;
    chk("R8 sel5", int'(rd_cnt), exp_h[5]);

    // R2: start clears a full histogram
    do_start();
    @(posedge clk); #1;
    read_all("R2 clear");

    // R5: pairs landing in one bin
    for (int i = 0; i < 10; i++) put(1'b1, 8'd5);
    for (int i = 0; i < 4; i++) put(1'b1, 8'd6);
    flush();
    read_all("R5 same bin");

    // R3: out-of-range values change nothing
    do_start();
    put(1'b1, 8'd8);   put(1'b1, 8'd200);
    put(1'b1, 8'd255); put(1'b1, 8'd9);
    put(1'b1, 8'd4);   put(1'b1, 8'd14);
    put(1'b1, 8'd15);  put(1'b1, 8'd1);
    flush();
    read_all("R3 range");

    // R6: samples with valid low are ignored
    do_start();
    for (int i = 0; i < 8; i++) put(1'b0, 8'd2);
    put(1'b1, 8'd3);
    put(1'b0, 8'd3);
    put(1'b0, 8'd0);
    put(1'b1, 8'd0);
    flush();
    read_all("R6 invalid");

    // R9: one falling-edge sample to the last bin
    do_start();
    rd_sel = 3'(NB - 1);
    next_rise = 1'b0;
    put(1'b1, 8'(NB - 1));
    put(1'b0, '0);
    put(1'b0, '0);
    repeat (NB/2 + 2) @(posedge clk);
    #2;
    chk("R9 not yet", int'(rd_cnt), 0);
    @(posedge clk); #2;
    chk("R9 arrived", int'(rd_cnt), 1);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule